// File: doc/BRIEF.md
# Serial Sync and Flag Detector

This block sits on one receive serial data line, sampled on the rising edge of the receive clock, and finds character framing. It can run in five modes: asynchronous, external sync, monosync, bisync and bit-oriented (flag) framing. In the three internal modes it compares a sliding window of received bits against a programmed pattern, or against the fixed flag in flag mode. The compare runs at every bit position. A hit drives the active-low sync pin for one clock and, while hunting, sets the character alignment. In external sync mode the sync pin is an input from outside logic that marks the boundary. In asynchronous mode the pin is a plain status input.

After alignment the block emits an assembled byte with a strobe every eight bits. A sync/hunt status bit, with a one-cycle change pulse, feeds a register read port elsewhere in the chip.

Top module: `sync_flag_detector`

## Requirements
- R1: Bits enter least-significant first. In monosync mode (mode 2), when the newest 8 received bits equal `sync_pattern[7:0]`, `sync_out_n` goes low for one clock, starting the cycle after the edge that sampled the last bit. This happens at any bit position, in or out of character alignment.
- R2: In bisync mode (mode 3), when the newest 16 received bits equal `sync_pattern` (the first character in `[7:0]`, the second in `[15:8]`), `sync_out_n` pulses low for one clock in the same way.
- R3: In flag mode (mode 4), the pattern is 8'h7E, and `sync_out_n` is low for exactly one clock per flag received.
- R4: `sync_oe` is high in modes 2, 3 and 4 and low in modes 0 (asynchronous) and 1 (external). `sync_out_n` is high whenever `sync_oe` is low.
- R5: The hunt state is entered on reset and on a `hunt_cmd` cycle; `hunt_cmd` has priority. It is left on the first match, or on the first external sync edge. On a match the bit count restarts, so the next 8 bits form the first character.
- R6: Outside the hunt state, and in any mode but asynchronous, `char_valid` pulses once every 8 bits with `char_data` holding those bits (first received in bit 0). No character is emitted while hunting.
- R7: In external mode, while hunting, the first clock that samples `sync_in` low after it was high marks the boundary. The bit sampled on the edge just before that clock is bit 0 of the first character.
- R8: In asynchronous mode, `sync_in` only affects the status. `sync_hunt` equals the inverted pin level delayed by two register stages, and no character is emitted.
- R9: In the synchronous modes `sync_hunt` shows the hunt state. `sync_hunt_chg` is high for one clock each time `sync_hunt` changes value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, rising edge samples data |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 1 | Receive serial data |
| mode | input | 3 | 0 async, 1 external, 2 monosync, 3 bisync, 4 flag |
| sync_pattern | input | 16 | Programmed sync character(s) |
| hunt_cmd | input | 1 | One-cycle command to re-enter hunt |
| sync_in | input | 1 | Sync pin as input, active low |
| sync_out_n | output | 1 | Sync pin output value, active low |
| sync_oe | output | 1 | Sync pin output enable |
| char_valid | output | 1 | Assembled character strobe |
| char_data | output | 8 | Assembled character |
| sync_hunt | output | 1 | Sync/hunt status bit |
| sync_hunt_chg | output | 1 | Status change-of-state pulse |

## Verification
If the shift window or the compare is wrong, `sync_out_n` shows a missing, extra or misplaced low pulse within one clock of the offending bit. A wrong bit counter or hunt flag shows up eight bits later at the latest, as a strobe in the wrong cycle or a rotated `char_data` byte, and the status bit also flips at the wrong moment. A reference model in the bench steps through every clock and compares all outputs each cycle. This catches a misalignment on the first byte after sync.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    typedef enum logic [2:0] {
        MODE_ASYNC = 3'd0,
        MODE_EXT   = 3'd1,
        MODE_MONO  = 3'd2,
        MODE_BI    = 3'd3,
        MODE_FLAG  = 3'd4
    } sfd_mode_e;

    localparam int         SFD_CHAR_W = 8;
    localparam logic [7:0] SFD_FLAG   = 8'h7E;
endpackage

// File: rtl/sfd_pin_sync.sv
module sfd_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic first_q,
    output logic last_q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign first_q = chain_q[0];
    assign last_q  = chain_q[STAGES-1];
endmodule

// File: rtl/sfd_matcher.sv
module sfd_matcher
    import sfd_pkg::*;
#(
    parameter int CHAR_W = SFD_CHAR_W,
    parameter int WIN_W  = 2 * CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_data,
    input  logic [2:0]        mode,
    input  logic [WIN_W-1:0]  pattern,
    output logic [WIN_W-1:0]  win_next,
    output logic              match
);
    logic [WIN_W-1:0]  sr_d, sr_q;
    logic [CHAR_W-1:0] newest;

    always_comb begin
        sr_d   = {rx_data, sr_q[WIN_W-1:1]};
        newest = sr_d[WIN_W-1 -: CHAR_W];
        match  = 1'b0;
        case (mode)
            MODE_MONO: match = (newest == pattern[CHAR_W-1:0]);
            MODE_BI:   match = (sr_d == pattern);
            MODE_FLAG: match = (newest == CHAR_W'(SFD_FLAG));
            default:   match = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign win_next = sr_d;
endmodule

// File: rtl/sync_flag_detector.sv
module sync_flag_detector
    import sfd_pkg::*;
#(
    parameter int CHAR_W     = SFD_CHAR_W,
    parameter int PIN_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_data,
    input  logic [2:0]          mode,
    input  logic [2*CHAR_W-1:0] sync_pattern,
    input  logic                hunt_cmd,
    input  logic                sync_in,
    output logic                sync_out_n,
    output logic                sync_oe,
    output logic                char_valid,
    output logic [CHAR_W-1:0]   char_data,
    output logic                sync_hunt,
    output logic                sync_hunt_chg
);
    localparam int               WIN_W  = 2 * CHAR_W;
    localparam int               CNT_W  = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CHAR_W - 1);
    localparam logic [CNT_W-1:0] CNT_EXT  = CNT_W'(2);

    typedef struct packed {
        logic              hunt;
        logic [CNT_W-1:0]  cnt;
        logic              pulse;
        logic              cval;
        logic [CHAR_W-1:0] cdata;
        logic              stat;
        logic              chg;
    } sfd_state_t;

    sfd_state_t       st_d, st_q;
    logic [WIN_W-1:0] win_next;
    logic             match;
    logic             pin_s1, pin_s2;
    logic             is_async, is_int, ext_edge;

    sfd_matcher #(.CHAR_W(CHAR_W), .WIN_W(WIN_W)) i_matcher (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_data  (rx_data),
        .mode     (mode),
        .pattern  (sync_pattern),
        .win_next (win_next),
        .match    (match)
    );

    sfd_pin_sync #(.STAGES(PIN_STAGES), .RST_VAL(1'b1)) i_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (sync_in),
        .first_q (pin_s1),
        .last_q  (pin_s2)
    );

    always_comb begin
        is_async = (mode == MODE_ASYNC);
        is_int   = (mode == MODE_MONO) || (mode == MODE_BI) || (mode == MODE_FLAG);
        ext_edge = (mode == MODE_EXT) && st_q.hunt && !sync_in && pin_s1;

        st_d      = st_q;
        st_d.cval = 1'b0;
        st_d.cnt  = (st_q.cnt == CNT_LAST) ? '0 : st_q.cnt + 1'b1;

        if (!is_async && !st_q.hunt && st_q.cnt == CNT_LAST) begin
            st_d.cval  = 1'b1;
            st_d.cdata = win_next[WIN_W-1 -: CHAR_W];
        end

        if (st_q.hunt && match) st_d.cnt = '0;
        else if (ext_edge)      st_d.cnt = CNT_EXT;

        if (hunt_cmd)                            st_d.hunt = 1'b1;
        else if (st_q.hunt && (match || ext_edge)) st_d.hunt = 1'b0;

        st_d.pulse = match && is_int;
        st_d.stat  = is_async ? ~pin_s2 : st_d.hunt;
        st_d.chg   = (st_d.stat != st_q.stat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.hunt  <= 1'b1;
            st_q.stat  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_oe       = is_int;
    assign sync_out_n    = !(is_int && st_q.pulse);
    assign char_valid    = st_q.cval;
    assign char_data     = st_q.cdata;
    assign sync_hunt     = st_q.stat;
    assign sync_hunt_chg = st_q.chg;

    assert_flag_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FLAG && $past(mode) == MODE_FLAG && !sync_out_n)
        |=> (sync_out_n || !$stable(mode)));

    assert_hunt_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> st_q.hunt);

    assert_no_char_hunting_R6: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> !$past(st_q.hunt));

    assert_pin_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_oe |-> sync_out_n);

    assert_async_no_char_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ASYNC && $past(mode) == MODE_ASYNC) |-> !char_valid);

    assert_chg_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hunt_chg |-> (sync_hunt != $past(sync_hunt)));
endmodule

// File: tb/test_sync_flag_detector.sv
`timescale 1ns/1ps
module test_sync_flag_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_data = 1'b0;
    logic [2:0]  mode = 3'd2;
    logic [15:0] sync_pattern = 16'h00A5;
    logic        hunt_cmd = 1'b0;
    logic        sync_in = 1'b1;
    logic        sync_out_n, sync_oe, char_valid, sync_hunt, sync_hunt_chg;
    logic [7:0]  char_data;

    int checks = 0;
    int fails  = 0;

    sync_flag_detector i_sync_flag_detector (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .mode(mode),
        .sync_pattern(sync_pattern), .hunt_cmd(hunt_cmd), .sync_in(sync_in),
        .sync_out_n(sync_out_n), .sync_oe(sync_oe), .char_valid(char_valid),
        .char_data(char_data), .sync_hunt(sync_hunt), .sync_hunt_chg(sync_hunt_chg)
    );

    always #2.5 clk = ~clk;

    // reference model state
    bit       hist[$];
    int       m_cnt;
    bit       m_hunt, m_pulse, m_cval, m_stat, m_chg, m_s1, m_s2;
    bit [7:0] m_cdata;
    logic [7:0] got[$];

    function automatic bit [15:0] window(input int n);
        bit [15:0] v = '0;
        for (int i = 0; i < n; i++) v[i] = hist[hist.size() - n + i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < 16; i++) hist.push_back(1'b0);
            m_cnt = 0; m_hunt = 1; m_pulse = 0; m_cval = 0; m_stat = 1;
            m_chg = 0; m_s1 = 1; m_s2 = 1; m_cdata = 0;
        end else begin
            bit [7:0]  w8;
            bit [15:0] w16;
            bit        mt, ee, nh, ns, o1, o2;
            int        nc;
            o1 = m_s1; o2 = m_s2;
            hist.push_back(rx_data);
            void'(hist.pop_front());
            w8  = window(8);
            w16 = window(16);
            mt = (mode == 2 && w8 == sync_pattern[7:0]) || (mode == 3 && w16 == sync_pattern)
                 || (mode == 4 && w8 == 8'h7E);
            ee = (mode == 1) && m_hunt && !sync_in && o1;
            m_cval = (mode != 0) && !m_hunt && (m_cnt == 7);
            if (m_cval) m_cdata = w8;
            nc = (m_cnt + 1) % 8;
            if (m_hunt && mt) nc = 0;
            else if (ee) nc = 2;
            nh = hunt_cmd ? 1'b1 : ((m_hunt && (mt || ee)) ? 1'b0 : m_hunt);
            m_pulse = mt;
            ns = (mode == 0) ? !o2 : nh;
            m_chg = (ns != m_stat);
            m_stat = ns; m_hunt = nh; m_cnt = nc;
            m_s2 = o1; m_s1 = sync_in;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit    eoe, eon;
            string tg;
            eoe = (mode == 2) || (mode == 3) || (mode == 4);
            eon = !(eoe && m_pulse);
            tg  = (mode == 2) ? "R1" : (mode == 3) ? "R2" : (mode == 4) ? "R3" : "R4";
            chk(sync_out_n == eon, {tg, " sync_out_n"}, sync_out_n, eon);
            chk(sync_oe == eoe, "R4 sync_oe", sync_oe, eoe);
            chk(char_valid == m_cval, (mode == 0) ? "R8 char_valid" : "R6 char_valid", char_valid, m_cval);
            if (m_cval) chk(char_data == m_cdata, "R6 char_data", char_data, m_cdata);
            chk(sync_hunt == m_stat, (mode == 0) ? "R8 sync_hunt" : "R9 sync_hunt", sync_hunt, m_stat);
            chk(sync_hunt_chg == m_chg, "R9 sync_hunt_chg", sync_hunt_chg, m_chg);
            if (char_valid) got.push_back(char_data);
        end
    end

    task automatic step(input logic b, input logic s);
        @(posedge clk);
        #1;
        rx_data  = b;
        sync_in  = s;
        hunt_cmd = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input logic s);
        for (int i = 0; i < 8; i++) step(v[i], s);
    endtask

    task automatic restart(input logic [2:0] m);
        @(posedge clk);
        #1;
        mode = m; hunt_cmd = 1'b1; rx_data = 1'b0;
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1);
        got.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // reset state: hunting, idle pin, no character
        chk(sync_hunt == 1'b1, "R5 reset hunt", sync_hunt, 1);
        chk(char_valid == 1'b0, "R6 reset char_valid", char_valid, 0);
        chk(sync_out_n == 1'b1, "R1 reset sync_out_n", sync_out_n, 1);

        // R1 monosync, pattern at an odd bit offset
        step(1, 1); step(1, 1); step(0, 1);
        send_byte(8'hA5, 1);
        send_byte(8'h12, 1); send_byte(8'h34, 1);
        step(0, 1); step(1, 1); step(0, 1);
        send_byte(8'hA5, 1); send_byte(8'h5A, 1);
        @(negedge clk);
        chk(got.size() > 0 && got[0] == 8'h12, "R1 first char after sync", got.size() > 0 ? got[0] : 0, 8'h12);

        // R5 hunt re-entry, R2 bisync
        sync_pattern = 16'h3C96;
        restart(3'd3);
        chk(sync_hunt == 1'b1, "R5 hunt after command", sync_hunt, 1);
        send_byte(8'h96, 1); send_byte(8'h3C, 1);
        send_byte(8'hC3, 1); send_byte(8'h0F, 1);
        @(negedge clk);
        chk(got.size() > 0 && got[0] == 8'hC3, "R2 first char after sync", got.size() > 0 ? got[0] : 0, 8'hC3);

        // R3 flag mode
        restart(3'd4);
        step(1, 1); step(0, 1); step(1, 1);
        send_byte(8'h7E, 1); send_byte(8'h81, 1);
        send_byte(8'h7E, 1); send_byte(8'h7E, 1); send_byte(8'h44, 1);
        @(negedge clk);
        chk(got.size() > 0 && got[0] == 8'h81, "R3 first char after flag", got.size() > 0 ? got[0] : 0, 8'h81);

        // R7 external sync
        restart(3'd1);
        send_byte(8'h6B, 1);
        step(1, 1);            // bit 0 of first character
        step(0, 0);            // bit 1, pin goes low here
        for (int i = 2; i < 8; i++) step(i[0], 0);
        send_byte(8'h27, 0);
        step(0, 1);
        @(negedge clk);
        chk(got.size() > 0 && got[0] == 8'hA9, "R7 external boundary char", got.size() > 0 ? got[0] : 0, 8'hA9);

        // R8 asynchronous: pin toggles only move the status
        restart(3'd0);
        for (int k = 0; k < 6; k++) begin
            step(k[0], 1'b0); step(1, 1'b0); step(0, 1'b0);
            step(k[1], 1'b1); step(1, 1'b1); step(0, 1'b1);
        end
        @(negedge clk);
        chk(got.size() == 0, "R8 no char in async", got.size(), 0);

        repeat (4) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule